// File: doc/BRIEF.md
# Indexed Event Counter Bank

A bank of hardware event counters, all reached through one narrow register window. A select register chooses which counter later window accesses act on. Through that window software binds the chosen counter to one of several condition inputs, loads its count as two 32-bit halves, and reads it back live. A snapshot command copies the chosen counter's whole value into one shared register pair in a single edge. Software can then read both halves of that copy without tearing, while the counter keeps running.

Every counter is gated by one global run bit. There is no per-counter enable. To park a counter, software binds it to condition number 0, which is wired to "never". A read-only build word reports that counters exist, how many there are, and the size code that sets their width (32 + 16*size bits). Counters wrap silently at that width. Each counter adds one on every clock in which the run bit is set and its bound condition input is high.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset every register reads zero (index, control, condition, count halves, snapshot halves). Every counter is therefore cleared, bound to "never" and stopped.
- R2: The window addresses are: 0 index, 1 control, 2 condition, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 build. The build word at address 7 reads bit 0 = 1, bits 15:8 = number of counters, bits 19:16 = size code, and zero elsewhere.
- R3: The index register holds the full 32-bit value written and reads it back. Condition, count and snapshot commands act on the counter it selects.
- R4: A counter bound to condition n (n > 0) gains exactly one on each clock edge where the run bit is 1 and condition input n is high.
- R5: A counter bound to condition 0 never changes by counting, whatever condition input 0 or the run bit do.
- R6: Control bit 0 is the global run bit. While it is 0, no counter counts. Control bits 31:16 are stored and read back. Control bit 1 is a write-only snapshot command that reads as 0.
- R7: Writing the count low or count high address replaces that half of the selected counter. A count write in the same cycle as a counting event wins, and that event is lost. Writing zero to both halves clears the counter.
- R8: A control write with bit 1 set copies the selected counter's value from just before that edge into the snapshot pair. The pair then holds that value until the next snapshot command, while the counter keeps running.
- R9: The counter is 32 + 16*size bits wide. It wraps from all ones to zero. Count high bits above the width are not stored and read as zero.
- R10: With an index of at least the number of counters, condition and count reads return zero, writes to them change no counter, and a snapshot command captures zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | NUM_COND | Condition inputs, level-sampled each clock; bit 0 is never used |
| reg_we_i | input | 1 | Write strobe for the register window |
| reg_addr_i | input | 3 | Window address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |

## Verification
If a counter's stored value or binding is wrong, the error shows at the very next read of count low or count high once that counter is selected. These reads are combinational, so no extra cycle is needed. A fault in the snapshot path shows only through the snapshot addresses. The bench therefore lets counters run on after each capture and compares the held pair against the value from the capture edge. A wrong index decode, or a stray write to a counter that is out of range or unselected, shows when the bench later returns to that counter and finds its count or condition binding changed.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  typedef enum logic [2:0] {
    WIN_IDX   = 3'd0,
    WIN_CTRL  = 3'd1,
    WIN_COND  = 3'd2,
    WIN_CLO   = 3'd3,
    WIN_CHI   = 3'd4,
    WIN_SLO   = 3'd5,
    WIN_SHI   = 3'd6,
    WIN_BUILD = 3'd7
  } win_addr_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SNAP_BIT = 1;
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
  parameter int NUM_COND = 8,
  parameter int CNT_W    = 48,
  localparam int CFG_W   = $clog2(NUM_COND)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic             run_i,
  input  logic             we_cfg_i,
  input  logic             we_lo_i,
  input  logic             we_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [63:0]      cnt_o
);
  localparam logic [63:0] CNT_MASK = (CNT_W >= 64) ? '1 : ((64'd1 << CNT_W) - 64'd1);

  logic [CFG_W-1:0] cfg_q;
  logic [63:0]      cnt_q, cnt_d, wide;
  logic             hit, any_we;

  assign hit    = run_i && (cfg_q != '0) && cond_i[cfg_q];
  assign any_we = we_lo_i || we_hi_i;

  always_comb begin
    wide = cnt_q;
    if (we_lo_i) wide[31:0]  = wdata_i;
    if (we_hi_i) wide[63:32] = wdata_i;
    if (!any_we && hit) wide = wide + 64'd1;
    cnt_d = wide & CNT_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (we_cfg_i) cfg_q <= wdata_i[CFG_W-1:0];
      cnt_q <= cnt_d;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == (($past(cnt_q) + 64'd1) & CNT_MASK)));
  // R5
  never_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q == '0 && !any_we) |=> $stable(cnt_q));
  // R6
  run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !any_we) |=> $stable(cnt_q));
  // R9
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MASK && run_i && cfg_q != '0 && cond_i[cfg_q] && !any_we) |=> cnt_q == '0);
  // R9
  width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q & ~CNT_MASK) == '0);
endmodule

// File: rtl/evt_cnt_regs.sv
module evt_cnt_regs
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int NUM_COND = 8,
  parameter int SIZE_SEL = 1,
  localparam int CFG_W   = $clog2(NUM_COND),
  localparam int SEL_W   = $clog2(NUM_CNT)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [2:0]                    addr_i,
  input  logic [31:0]                   wdata_i,
  output logic [31:0]                   rdata_o,
  input  logic [NUM_CNT-1:0][63:0]      cnt_all_i,
  input  logic [NUM_CNT-1:0][CFG_W-1:0] cfg_all_i,
  output logic                          run_o,
  output logic [NUM_CNT-1:0]            we_cfg_o,
  output logic [NUM_CNT-1:0]            we_lo_o,
  output logic [NUM_CNT-1:0]            we_hi_o
);
  localparam logic [31:0] BUILD_WORD = {12'd0, 4'(SIZE_SEL), 8'(NUM_CNT), 7'd0, 1'b1};

  logic [31:0]      idx_q;
  logic             run_q;
  logic [15:0]      ctrl_hi_q;
  logic [63:0]      snap_q;
  logic             idx_ok;
  logic [63:0]      cnt_sel;
  logic [CFG_W-1:0] cfg_sel;
  logic             snap_cmd;
  win_addr_e        waddr;

  assign waddr    = win_addr_e'(addr_i);
  assign idx_ok   = idx_q < 32'(NUM_CNT);
  assign cnt_sel  = idx_ok ? cnt_all_i[idx_q[SEL_W-1:0]] : '0;
  assign cfg_sel  = idx_ok ? cfg_all_i[idx_q[SEL_W-1:0]] : '0;
  assign snap_cmd = we_i && (waddr == WIN_CTRL) && wdata_i[CTRL_SNAP_BIT];

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      we_cfg_o[k] = we_i && idx_ok && (idx_q[SEL_W-1:0] == SEL_W'(k)) && (waddr == WIN_COND);
      we_lo_o[k]  = we_i && idx_ok && (idx_q[SEL_W-1:0] == SEL_W'(k)) && (waddr == WIN_CLO);
      we_hi_o[k]  = we_i && idx_ok && (idx_q[SEL_W-1:0] == SEL_W'(k)) && (waddr == WIN_CHI);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      run_q     <= 1'b0;
      ctrl_hi_q <= '0;
      snap_q    <= '0;
    end else begin
      if (we_i && waddr == WIN_IDX) idx_q <= wdata_i;
      if (we_i && waddr == WIN_CTRL) begin
        run_q     <= wdata_i[CTRL_RUN_BIT];
        ctrl_hi_q <= wdata_i[31:16];
      end
      if (snap_cmd) snap_q <= cnt_sel;
    end
  end

  always_comb begin
    unique case (waddr)
      WIN_IDX:   rdata_o = idx_q;
      WIN_CTRL:  rdata_o = {ctrl_hi_q, 15'd0, run_q};
      WIN_COND:  rdata_o = 32'(cfg_sel);
      WIN_CLO:   rdata_o = cnt_sel[31:0];
      WIN_CHI:   rdata_o = cnt_sel[63:32];
      WIN_SLO:   rdata_o = snap_q[31:0];
      WIN_SHI:   rdata_o = snap_q[63:32];
      WIN_BUILD: rdata_o = BUILD_WORD;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o = run_q;

  // R8
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd1 && wdata_i[1]) |=> $stable(snap_q));
  // R6
  snap_bit_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd1) |-> !rdata_o[1]);
  // R10
  oob_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= 32'(NUM_CNT) && (addr_i == 3'd2 || addr_i == 3'd3 || addr_i == 3'd4)) |-> rdata_o == '0);
  // R10
  oob_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q >= 32'(NUM_CNT)) |-> (we_cfg_o == '0 && we_lo_o == '0 && we_hi_o == '0));
  // R3
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_cfg_o | we_lo_o | we_hi_o));
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank #(
  parameter int NUM_CNT  = 4,
  parameter int NUM_COND = 8,
  parameter int SIZE_SEL = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o
);
  localparam int CNT_W = 32 + 16 * SIZE_SEL;
  localparam int CFG_W = $clog2(NUM_COND);

  logic [NUM_CNT-1:0][63:0]      cnt_all;
  logic [NUM_CNT-1:0][CFG_W-1:0] cfg_all;
  logic [NUM_CNT-1:0]            we_cfg, we_lo, we_hi;
  logic                          run;

  evt_cnt_regs #(
    .NUM_CNT (NUM_CNT),
    .NUM_COND(NUM_COND),
    .SIZE_SEL(SIZE_SEL)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .cnt_all_i(cnt_all),
    .cfg_all_i(cfg_all),
    .run_o    (run),
    .we_cfg_o (we_cfg),
    .we_lo_o  (we_lo),
    .we_hi_o  (we_hi)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slice
    evt_cnt_slice #(
      .NUM_COND(NUM_COND),
      .CNT_W   (CNT_W)
    ) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cond_i  (cond_i),
      .run_i   (run),
      .we_cfg_i(we_cfg[g]),
      .we_lo_i (we_lo[g]),
      .we_hi_i (we_hi[g]),
      .wdata_i (reg_wdata_i),
      .cfg_o   (cfg_all[g]),
      .cnt_o   (cnt_all[g])
    );
  end

  // R6
  run_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !reg_we_i) |=> $stable(cnt_all));
endmodule

// File: tb/tb_evt_cnt_bank.sv
`timescale 1ns/1ps
module tb_evt_cnt_bank;
  localparam int NC = 4;
  localparam logic [2:0] A_IDX = 3'd0, A_CTRL = 3'd1, A_COND = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_SLO = 3'd5, A_SHI = 3'd6, A_BUILD = 3'd7;
  localparam logic [63:0] MASK48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cond = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int errors = 0;
  logic [63:0] exp_cnt [NC];
  int cfgv [NC];
  logic [31:0] v;

  always #10 clk = ~clk;

  evt_cnt_bank #(.NUM_CNT(4), .NUM_COND(8), .SIZE_SEL(1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk_cnt(input string tag, input int i, input logic [63:0] e);
    logic [31:0] r;
    wr(A_IDX, 32'(i));
    rd(A_CLO, r); chk(tag, r, e[31:0]);
    rd(A_CHI, r); chk(tag, r, e[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfgv[0] = 1; cfgv[1] = 2; cfgv[2] = 7; cfgv[3] = 0;
    for (int i = 0; i < NC; i++) exp_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk("R1 reset read", v, 32'd0);
    end
    // R2: build word
    rd(A_BUILD, v); chk("R2 build", v, 32'h0001_0401);

    // R3: bind conditions, read back
    for (int i = 0; i < NC; i++) begin
      wr(A_IDX, 32'(i));
      wr(A_COND, 32'(cfgv[i]));
    end
    for (int i = 0; i < NC; i++) begin
      wr(A_IDX, 32'(i));
      rd(A_IDX, v);  chk("R3 index", v, 32'(i));
      rd(A_COND, v); chk("R3 cond", v, 32'(cfgv[i]));
    end

    // R4 R5: sweep every condition pattern with run set
    wr(A_CTRL, 32'h1);
    for (int p = 0; p < 256; p++) begin
      cond = 8'(p);
      @(negedge clk);
      for (int i = 0; i < NC; i++)
        if (cfgv[i] != 0 && cond[cfgv[i]]) exp_cnt[i] = exp_cnt[i] + 64'd1;
    end
    cond = '0;
    for (int i = 0; i < NC; i++) chk_cnt("R4 R5 sweep count", i, exp_cnt[i]);

    // R6: run clear stops everything, upper control bits kept
    wr(A_CTRL, 32'hABCD_0000);
    cond = 8'hFF;
    repeat (10) @(negedge clk);
    cond = '0;
    for (int i = 0; i < NC; i++) chk_cnt("R6 stopped", i, exp_cnt[i]);
    rd(A_CTRL, v); chk("R6 ctrl readback", v, 32'hABCD_0000);

    // R8: snapshot of counter 1, control bit 1 reads zero
    wr(A_IDX, 32'd1);
    wr(A_CTRL, 32'hABCD_0003);
    rd(A_CTRL, v); chk("R6 snap bit reads zero", v, 32'hABCD_0001);
    rd(A_SLO, v);  chk("R8 snap lo", v, exp_cnt[1][31:0]);
    rd(A_SHI, v);  chk("R8 snap hi", v, exp_cnt[1][63:32]);

    // R9: preload near the top and wrap
    wr(A_IDX, 32'd0);
    wr(A_CHI, 32'hFFFF_FFFF);
    wr(A_CLO, 32'hFFFF_FFFE);
    rd(A_CHI, v); chk("R9 high bits above width", v, 32'h0000_FFFF);
    exp_cnt[0] = 64'h0000_FFFF_FFFF_FFFE;
    cond = 8'h02;
    repeat (3) @(negedge clk);
    cond = '0;
    exp_cnt[0] = (exp_cnt[0] + 64'd3) & MASK48;
    rd(A_CLO, v); chk("R9 wrap lo", v, exp_cnt[0][31:0]);
    rd(A_CHI, v); chk("R9 wrap hi", v, exp_cnt[0][63:32]);

    // R7: write wins over a same-cycle count event
    @(negedge clk);
    cond = 8'h02; addr = A_CLO; wdata = 32'h100; we = 1'b1;
    @(negedge clk);
    we = 1'b0; cond = '0;
    exp_cnt[0] = 64'h100;
    rd(A_CLO, v); chk("R7 write precedence", v, 32'h100);

    // R8: capture while counting, pair holds as counter runs on
    cond = 8'h02;
    repeat (5) @(negedge clk);
    addr = A_CTRL; wdata = 32'h3; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    repeat (10) @(negedge clk);
    cond = '0;
    rd(A_SLO, v); chk("R8 held snap lo", v, 32'h105);
    rd(A_SHI, v); chk("R8 held snap hi", v, 32'h0);
    rd(A_CLO, v); chk("R8 live count", v, 32'h110);
    wr(A_CHI, 32'h1234);
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h3);
    rd(A_SHI, v); chk("R8 snap hi half", v, 32'h1234);
    rd(A_SLO, v); chk("R8 snap lo half", v, 32'hFFFF_FFFF);
    // R7: clear by zeroing both halves
    wr(A_CHI, 32'h0);
    wr(A_CLO, 32'h0);
    exp_cnt[0] = '0;
    chk_cnt("R7 clear", 0, 64'd0);

    // R10: out-of-range index
    wr(A_IDX, 32'd5);
    rd(A_IDX, v);  chk("R10 index readback", v, 32'd5);
    rd(A_COND, v); chk("R10 cond read", v, 32'd0);
    rd(A_CLO, v);  chk("R10 lo read", v, 32'd0);
    rd(A_CHI, v);  chk("R10 hi read", v, 32'd0);
    wr(A_COND, 32'd3);
    wr(A_CLO, 32'h55);
    wr(A_CHI, 32'h66);
    wr(A_CTRL, 32'h3);
    rd(A_SLO, v); chk("R10 snap lo zero", v, 32'd0);
    rd(A_SHI, v); chk("R10 snap hi zero", v, 32'd0);
    for (int i = 0; i < NC; i++) begin
      chk_cnt("R10 counters untouched", i, exp_cnt[i]);
      rd(A_COND, v); chk("R10 cond untouched", v, 32'(cfgv[i]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule